// File: doc/BRIEF.md
# Stall-Go Link Flow Controller

This block applies back-pressure to the output links of a mesh router so that no flit is ever dropped under congestion. Each link has a small three-state machine with the states Stop, Go and Sent. The machine sits between the input buffering and the switch scheduler. It watches two inputs: an early-warning "almost full" flag from the receiving FIFO downstream, and a strobe from the scheduler that marks each cycle in which a flit actually left on that link. From these it produces a go/stop permission for the scheduler.

The permission is a Mealy output. It follows the almost-full flag in the same cycle, so the scheduler stops offering flits as soon as the receiver warns. The receiver raises its warning while it still has one free slot. That slot absorbs the flit that may already be leaving during the cycle in which the warning appears.

The block always reports the state of every machine, so the scheduler can tell a link that has just carried a flit from one that is idle. One instance serves every link of a router; the number of links is a parameter. A parameter also selects an alternative variant in which the permission is taken from the registered state.

Top module: `sg_flow_ctrl`

## Requirements
- R1: After reset is released, every link is in state Go, coded 2'b01, and with almost_full low its go output is 1.
- R2: Link i reports its state on state_o[2i+1:2i] with Stop = 2'b00, Go = 2'b01 and Sent = 2'b10. The code 2'b11 never appears.
- R3: While almost_full_i[i] is 1, go_o[i] is 0 in that same cycle, whatever the link's state.
- R4: While almost_full_i[i] is 0, go_o[i] is 1 in that same cycle, whatever the link's state.
- R5: A clock edge at which flit_sent_i[i] is 1 puts link i in Sent for the next cycle, whatever the value of almost_full_i[i].
- R6: A clock edge at which flit_sent_i[i] is 0 and almost_full_i[i] is 1 puts link i in Stop. This applies from Sent as well as from Go and Stop.
- R7: A clock edge at which flit_sent_i[i] is 0 and almost_full_i[i] is 0 puts link i in Go. This applies from Stop and from Sent.
- R8: The links are independent: the inputs of one link never change the state or the go output of another.
- R9: A flit reported as sent while go_o[i] is 0 is still recorded: the link enters Sent and is not held in Stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| almost_full_i | input | NUM_LINKS | Per-link early-full warning from the downstream FIFO |
| flit_sent_i | input | NUM_LINKS | Per-link strobe: a flit left on this link this cycle |
| go_o | output | NUM_LINKS | Per-link permission to send (1 = go, 0 = stop) |
| state_o | output | 2*NUM_LINKS | Per-link machine state, 2 bits per link |

## Verification
The go outputs are combinational, so the bench checks them one time step after it drives new inputs, in the same cycle. The state is registered, so each link's state is due one rising edge after the inputs that cause it. The bench compares the state at the following falling edge, against a behavioural model that it advances at that same rising edge. The inputs change only at falling edges, which keeps both samples clear of the active edge.

// File: rtl/sg_pkg.sv
package sg_pkg;
   localparam int SG_STATE_W = 2;

   typedef enum logic [SG_STATE_W-1:0] {
      SG_STOP = 2'b00,
      SG_GO   = 2'b01,
      SG_SENT = 2'b10
   } sg_state_e;
endpackage

// File: rtl/sg_link_fsm.sv
module sg_link_fsm
   import sg_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      almost_full_i,
   input  logic      flit_sent_i,
   output logic      go_o,
   output sg_state_e state_o
);
   sg_state_e state_q;
   sg_state_e state_d;

   // a recorded departure wins over the warning: the flit is never lost
   always_comb begin
      if (flit_sent_i)        state_d = SG_SENT;
      else if (almost_full_i) state_d = SG_STOP;
      else                    state_d = SG_GO;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SG_GO;
      else        state_q <= state_d;
   end

   generate
      if (REG_OUT) begin : g_moore
         assign go_o = (state_q != SG_STOP);
      end else begin : g_mealy
         assign go_o = ~almost_full_i;
      end
   endgenerate

   assign state_o = state_q;
endmodule

// File: rtl/sg_flow_ctrl.sv
module sg_flow_ctrl
   import sg_pkg::*;
#(
   parameter int NUM_LINKS = 5,
   parameter bit REG_OUT   = 1'b0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_LINKS-1:0]            almost_full_i,
   input  logic [NUM_LINKS-1:0]            flit_sent_i,
   output logic [NUM_LINKS-1:0]            go_o,
   output logic [SG_STATE_W*NUM_LINKS-1:0] state_o
);
   localparam int ST_BITS = SG_STATE_W * NUM_LINKS;

   generate
      if (NUM_LINKS < 1) begin : g_bad_links
         $error("sg_flow_ctrl: NUM_LINKS must be at least 1");
      end
      if (ST_BITS != $bits(state_o)) begin : g_bad_width
         $error("sg_flow_ctrl: state vector width mismatch");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < NUM_LINKS; gi++) begin : g_link
         sg_state_e link_state;
         sg_link_fsm #(.REG_OUT(REG_OUT)) u_fsm (
            .clk           (clk),
            .rst_n         (rst_n),
            .almost_full_i (almost_full_i[gi]),
            .flit_sent_i   (flit_sent_i[gi]),
            .go_o          (go_o[gi]),
            .state_o       (link_state)
         );
         assign state_o[SG_STATE_W*gi +: SG_STATE_W] = link_state;
      end
   endgenerate
endmodule

// File: rtl/sg_flow_ctrl_chk.sv
module sg_flow_ctrl_chk
   import sg_pkg::*;
#(
   parameter int NUM_LINKS = 5,
   parameter bit REG_OUT   = 1'b0
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [NUM_LINKS-1:0]            almost_full_i,
   input logic [NUM_LINKS-1:0]            flit_sent_i,
   input logic [NUM_LINKS-1:0]            go_o,
   input logic [SG_STATE_W*NUM_LINKS-1:0] state_o
);
   genvar ci;
   generate
      for (ci = 0; ci < NUM_LINKS; ci++) begin : g_chk
         wire [1:0] st = state_o[SG_STATE_W*ci +: SG_STATE_W];

         AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            st != 2'b11); // R2
         AST_SENT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
            flit_sent_i[ci] |=> st == SG_SENT); // R5
         AST_FULL_TO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
            (!flit_sent_i[ci] && almost_full_i[ci]) |=> st == SG_STOP); // R6
         AST_FREE_TO_GO: assert property (@(posedge clk) disable iff (!rst_n)
            (!flit_sent_i[ci] && !almost_full_i[ci]) |=> st == SG_GO); // R7
         if (!REG_OUT) begin : g_mealy_chk
            AST_HOLD_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
               (st == SG_STOP && almost_full_i[ci]) |-> !go_o[ci]); // R3
            AST_RELEASE_GO: assert property (@(posedge clk) disable iff (!rst_n)
               (st == SG_STOP && !almost_full_i[ci]) |-> go_o[ci]); // R4
         end
      end
   endgenerate
endmodule

bind sg_flow_ctrl sg_flow_ctrl_chk #(
   .NUM_LINKS (NUM_LINKS),
   .REG_OUT   (REG_OUT)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .almost_full_i (almost_full_i),
   .flit_sent_i   (flit_sent_i),
   .go_o          (go_o),
   .state_o       (state_o)
);

// File: tb/sim_sg_flow_ctrl.sv
module sim_sg_flow_ctrl;
   localparam int NL = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NL-1:0]   nf = '0;
   logic [NL-1:0]   sd = '0;
   logic [NL-1:0]   go;
   logic [2*NL-1:0] st;

   int    checks = 0;
   int    fails = 0;
   bit    done = 0;
   int    exp_st [NL];
   string tag_st [NL];

   always #5 clk = ~clk;

   sg_flow_ctrl #(.NUM_LINKS(NL), .REG_OUT(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .almost_full_i(nf), .flit_sent_i(sd),
      .go_o(go), .state_o(st)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one cycle: check the registered state, drive, check go, advance the model
   task automatic cyc(logic [NL-1:0] n, logic [NL-1:0] s, string ovr = "");
      @(negedge clk);
      for (int i = 0; i < NL; i++) begin
         chk({tag_st[i], " state"}, int'(st[2*i +: 2]), exp_st[i]);
         if (st[2*i +: 2] == 2'b11) chk("R2 illegal code", 3, 0);
      end
      nf = n;
      sd = s;
      #1;
      for (int i = 0; i < NL; i++)
         chk(n[i] ? "R3 go" : "R4 go", int'(go[i]), n[i] ? 0 : 1);
      @(posedge clk);
      for (int i = 0; i < NL; i++) begin
         if (s[i])      begin exp_st[i] = 2; tag_st[i] = "R5"; end
         else if (n[i]) begin exp_st[i] = 0; tag_st[i] = "R6"; end
         else           begin exp_st[i] = 1; tag_st[i] = "R7"; end
         if (ovr != "") tag_st[i] = ovr;
      end
   endtask

   initial begin
      for (int i = 0; i < NL; i++) begin exp_st[i] = 1; tag_st[i] = "R1"; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      for (int i = 0; i < NL; i++) begin
         chk("R1 reset state", int'(st[2*i +: 2]), 1);
         chk("R1 reset go", int'(go[i]), 1);
      end
      // go -> stop -> stay -> go
      cyc(5'b11111, 5'b00000);
      cyc(5'b11111, 5'b00000);
      cyc(5'b00000, 5'b00000);
      // sent, then sent -> stop and sent -> go
      cyc(5'b00000, 5'b11111);
      cyc(5'b11111, 5'b00000);
      cyc(5'b00000, 5'b11111);
      cyc(5'b00000, 5'b00000);
      // flit recorded while stopped
      cyc(5'b11111, 5'b00000);
      cyc(5'b11111, 5'b11111, "R9");
      cyc(5'b11111, 5'b00000);
      // mixed per-link patterns
      cyc(5'b10100, 5'b01010, "R8");
      cyc(5'b01011, 5'b10000, "R8");
      cyc(5'b00110, 5'b00001, "R8");
      for (int k = 0; k < 600; k++)
         cyc(NL'($urandom), NL'($urandom));
      cyc('0, '0);
      cyc('0, '0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule